// File: doc/BRIEF.md
# Receive Event Request Handshake

This block sits between a telegram matcher and a byte-wide register port driven by a serial-bus slave. It holds the operating-mode register, a status register with a changed flag and a valid flag, the channel and button values that were last reported, and an acknowledge register. It also drives an active-low, open-drain request line that tells the host there is something to read.

The matcher reports begin-of-telegram events, which carry a channel and a button, and end-of-reception events. The first event after an acknowledge is shown to the host right away, and that report then stays frozen. Any later event is parked in a single slot, and a newer event overwrites an older one there. When the host reads the acknowledge register, the block releases the request line if nothing is parked. If an event is parked, the block moves it into the visible registers in the same cycle and keeps the changed flag set.

A register address pointer selects the register reached by each byte access. The first byte of a write transfer loads the pointer. Every byte read or written afterwards advances the pointer by one.

Top module: `rxevt_handshake`

## Requirements
- R1: After reset the mode is 0, the pointer is 0x00, the changed and valid flags are 0, and the request drive-low enable is 1.
- R2: A write to register 0x00 with a value from 0 to 6 sets the mode from the next cycle on, and `mode_o` and reads of 0x00 return it. Writes of values 7 to 255 leave the mode unchanged.
- R3: The request drive-low enable is 1 in mode 0. In modes 2 and 4 it equals the changed flag. In modes 1, 3, 5 and 6 it is 0. Whenever the block drives the line low, the wired line reads low.
- R4: Reading register 0x01 returns the changed flag in bit 7, the valid flag in bit 6 and zeros in bits 5..0. Writes to 0x01 are ignored.
- R5: An event is accepted only in modes 2 to 5. An accepted begin event, with changed at 0, sets changed=1 and valid=1 and latches the channel (read at 0x02) and the button (read at 0x03). An accepted end event, with changed at 0, sets changed=1 and valid=0 and keeps the channel and button.
- R6: While changed is 1, the channel, the button and the valid flag do not follow new events.
- R7: Reading register 0x06 returns 0x00. If no event is parked, that read clears changed in the next cycle.
- R8: An event that arrives while changed is 1 is parked, and the newest one wins. An acknowledge read then shows the parked event, and changed stays 1.
- R9: The first byte of a write transfer loads the pointer. Every other byte access increments the pointer modulo 256. Unmapped addresses read as 0x00.
- R10: A write to 0x03 changes only the stored button value. Writes to 0x02 and 0x06 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | One register byte access this cycle |
| acc_write | input | 1 | 1 = write byte, 0 = read byte |
| acc_first | input | 1 | Write byte is the register address |
| acc_wdata | input | 8 | Write byte |
| rd_data | output | 8 | Register at the current pointer |
| evt_begin | input | 1 | Begin-of-telegram event from matcher |
| evt_end | input | 1 | End-of-reception event from matcher |
| evt_chan | input | 8 | Channel of the begin event |
| evt_btn | input | 8 | Button of the begin event |
| mode_o | output | 3 | Current mode for the radio side |
| req_drive_low | output | 1 | Open-drain pull-down enable of the request line |
| req_line | input | 1 | Observed level of the wired request line |

## Verification
Directed sequences step through each mode with begin and end events, so that request-driven modes can be told apart from polled modes. They acknowledge with and without a parked event, which separates clearing the changed flag from reloading the visible registers. They also include writes to read-only addresses and out-of-range mode values, to show that those writes are rejected. A long seeded random mix of events, pointer loads, writes and reads then runs against a bench model. This catches ordering faults, such as a parked event being lost or the frozen values being overwritten. It also catches pointer wrap.

// File: rtl/rxevt_pkg.sv
package rxevt_pkg;

  typedef enum logic [2:0] {
    MD_PWD_RST = 3'd0,
    MD_PWD     = 3'd1,
    MD_RX_REQ  = 3'd2,
    MD_RX_POLL = 3'd3,
    MD_LN_REQ  = 3'd4,
    MD_LN_POLL = 3'd5,
    MD_DEL     = 3'd6
  } mode_e;

  localparam int MODE_W    = 3;
  localparam int MODE_LAST = 6;

  localparam int RA_MODE = 8'h00;
  localparam int RA_STAT = 8'h01;
  localparam int RA_CHAN = 8'h02;
  localparam int RA_BTN  = 8'h03;
  localparam int RA_ACK  = 8'h06;

  function automatic logic is_req_mode(mode_e m);
    return (m == MD_RX_REQ) || (m == MD_LN_REQ);
  endfunction

  function automatic logic is_listen_mode(mode_e m);
    return (m == MD_RX_REQ) || (m == MD_RX_POLL) ||
           (m == MD_LN_REQ) || (m == MD_LN_POLL);
  endfunction

endpackage

// File: rtl/rxevt_addr_ptr.sv
module rxevt_addr_ptr #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_write,
  input  logic              acc_first,
  input  logic [ADDR_W-1:0] acc_wdata,
  output logic [ADDR_W-1:0] ptr_o
);

  logic [ADDR_W-1:0] ptr_q, ptr_nxt;
  logic              ptr_en;

  always_comb begin
    ptr_en  = acc_en;
    ptr_nxt = ptr_q;
    if (acc_write && acc_first) ptr_nxt = acc_wdata;
    else                        ptr_nxt = ptr_q + ADDR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_nxt;
  end

  assign ptr_o = ptr_q;

  // R9: data byte accesses step the pointer by one
  assert_ptr_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !(acc_write && acc_first)) |=> (ptr_q == $past(ptr_q) + ADDR_W'(1)));

  // R9: address byte loads the pointer
  assert_ptr_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_write && acc_first) |=> (ptr_q == $past(acc_wdata)));

endmodule

// File: rtl/rxevt_mode_req.sv
module rxevt_mode_req
  import rxevt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              changed,
  output mode_e             mode_o,
  output logic              listen_o,
  output logic              req_drive_low
);

  mode_e mode_q, mode_nxt;
  logic  mode_en;

  always_comb begin
    mode_en  = mode_we && (wdata <= DATA_W'(MODE_LAST));
    mode_nxt = mode_e'(wdata[MODE_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= MD_PWD_RST;
    else if (mode_en) mode_q <= mode_nxt;
  end

  assign mode_o        = mode_q;
  assign listen_o      = is_listen_mode(mode_q);
  assign req_drive_low = (mode_q == MD_PWD_RST) || (changed && is_req_mode(mode_q));

  // R2: accepted mode value visible next cycle
  assert_mode_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_we && (wdata <= DATA_W'(MODE_LAST))) |=> (mode_q == $past(wdata[MODE_W-1:0])));

  // R2: out-of-range values ignored
  assert_mode_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_we && (wdata > DATA_W'(MODE_LAST))) |=> $stable(mode_q));

endmodule

// File: rtl/rxevt_evt_latch.sv
module rxevt_evt_latch #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_begin,
  input  logic              evt_end,
  input  logic [DATA_W-1:0] evt_chan,
  input  logic [DATA_W-1:0] evt_btn,
  input  logic              ack,
  input  logic              btn_we,
  input  logic [DATA_W-1:0] btn_wdata,
  output logic              changed_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] chan_o,
  output logic [DATA_W-1:0] btn_o
);

  // visible report
  logic              chg_q, chg_n;
  logic              val_q, val_n;
  logic [DATA_W-1:0] chan_q, chan_n;
  logic [DATA_W-1:0] btn_q, btn_n;
  // parked event slot
  logic              pv_q, pv_n;
  logic              pb_q, pb_n;
  logic [DATA_W-1:0] pc_q, pc_n;
  logic [DATA_W-1:0] pt_q, pt_n;
  // after-acknowledge intermediate
  logic              chg_a, val_a, pv_a;
  logic [DATA_W-1:0] chan_a, btn_a;
  logic              evt_any;

  always_comb begin
    chg_a  = chg_q;
    val_a  = val_q;
    chan_a = chan_q;
    btn_a  = btn_q;
    pv_a   = pv_q;
    if (btn_we) btn_a = btn_wdata;
    if (ack) begin
      if (pv_q) begin
        chg_a = 1'b1;
        val_a = pb_q;
        if (pb_q) begin
          chan_a = pc_q;
          btn_a  = pt_q;
        end
        pv_a = 1'b0;
      end else begin
        chg_a = 1'b0;
      end
    end

    evt_any = evt_begin || evt_end;
    chg_n  = chg_a;
    val_n  = val_a;
    chan_n = chan_a;
    btn_n  = btn_a;
    pv_n   = pv_a;
    pb_n   = pb_q;
    pc_n   = pc_q;
    pt_n   = pt_q;
    if (evt_any) begin
      if (!chg_a) begin
        chg_n = 1'b1;
        val_n = evt_begin;
        if (evt_begin) begin
          chan_n = evt_chan;
          btn_n  = evt_btn;
        end
      end else begin
        pv_n = 1'b1;
        pb_n = evt_begin;
        if (evt_begin) begin
          pc_n = evt_chan;
          pt_n = evt_btn;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chg_q  <= 1'b0;
      val_q  <= 1'b0;
      chan_q <= '0;
      btn_q  <= '0;
      pv_q   <= 1'b0;
      pb_q   <= 1'b0;
      pc_q   <= '0;
      pt_q   <= '0;
    end else begin
      chg_q  <= chg_n;
      val_q  <= val_n;
      chan_q <= chan_n;
      btn_q  <= btn_n;
      pv_q   <= pv_n;
      pb_q   <= pb_n;
      pc_q   <= pc_n;
      pt_q   <= pt_n;
    end
  end

  assign changed_o = chg_q;
  assign valid_o   = val_q;
  assign chan_o    = chan_q;
  assign btn_o     = btn_q;

  // R6: report frozen while changed and not acknowledged
  assert_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_q && !ack) |=> ($stable(chan_q) && $stable(val_q)));

  assert_freeze_btn_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_q && !ack && !btn_we) |=> $stable(btn_q));

  // R8: acknowledge with a parked event keeps changed set
  assert_park_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && pv_q) |=> chg_q);

  // R7: acknowledge with nothing parked clears changed
  assert_ack_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !pv_q && !evt_any) |=> !chg_q);

  // R5: begin event on an idle report sets both flags
  assert_begin_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_begin && !chg_q) |=> (chg_q && val_q));

endmodule

// File: rtl/rxevt_handshake.sv
module rxevt_handshake
  import rxevt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_write,
  input  logic              acc_first,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] rd_data,
  input  logic              evt_begin,
  input  logic              evt_end,
  input  logic [DATA_W-1:0] evt_chan,
  input  logic [DATA_W-1:0] evt_btn,
  output logic [2:0]        mode_o,
  output logic              req_drive_low,
  input  logic              req_line
);

  localparam int ADDR_W = DATA_W;

  logic [ADDR_W-1:0] ptr;
  logic              wr_hit, rd_hit;
  logic              mode_we, btn_we, ack;
  logic              listen;
  logic              evt_begin_g, evt_end_g;
  logic              changed, valid;
  logic [DATA_W-1:0] chan, btn;
  mode_e             mode;

  rxevt_addr_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_en    (acc_en),
    .acc_write (acc_write),
    .acc_first (acc_first),
    .acc_wdata (acc_wdata),
    .ptr_o     (ptr)
  );

  always_comb begin
    wr_hit  = acc_en && acc_write && !acc_first;
    rd_hit  = acc_en && !acc_write;
    mode_we = wr_hit && (ptr == ADDR_W'(RA_MODE));
    btn_we  = wr_hit && (ptr == ADDR_W'(RA_BTN));
    ack     = rd_hit && (ptr == ADDR_W'(RA_ACK));
  end

  rxevt_mode_req #(.DATA_W(DATA_W)) u_mode (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_we       (mode_we),
    .wdata         (acc_wdata),
    .changed       (changed),
    .mode_o        (mode),
    .listen_o      (listen),
    .req_drive_low (req_drive_low)
  );

  assign evt_begin_g = evt_begin && listen;
  assign evt_end_g   = evt_end && !evt_begin && listen;

  rxevt_evt_latch #(.DATA_W(DATA_W)) u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_begin (evt_begin_g),
    .evt_end   (evt_end_g),
    .evt_chan  (evt_chan),
    .evt_btn   (evt_btn),
    .ack       (ack),
    .btn_we    (btn_we),
    .btn_wdata (acc_wdata),
    .changed_o (changed),
    .valid_o   (valid),
    .chan_o    (chan),
    .btn_o     (btn)
  );

  always_comb begin
    rd_data = '0;
    if (ptr == ADDR_W'(RA_MODE)) begin
      rd_data[MODE_W-1:0] = mode;
    end else if (ptr == ADDR_W'(RA_STAT)) begin
      rd_data[DATA_W-1] = changed;
      rd_data[DATA_W-2] = valid;
    end else if (ptr == ADDR_W'(RA_CHAN)) begin
      rd_data = chan;
    end else if (ptr == ADDR_W'(RA_BTN)) begin
      rd_data = btn;
    end
  end

  assign mode_o = mode;

  // R3: a driven-low request is seen low on the wired line
  assert_line_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_drive_low |-> !req_line);

  // R3: polled and idle modes never pull the line
  assert_polled_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_PWD || mode == MD_RX_POLL || mode == MD_LN_POLL || mode == MD_DEL)
      |-> !req_drive_low);

  // R7: the acknowledge register reads as zero
  assert_ack_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (rd_data == '0));

  // R5: events outside listening modes leave the report untouched
  assert_deaf_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_begin || evt_end) && !listen && !changed && !btn_we) |=> !changed);

endmodule

// File: tb/test_rxevt_handshake.sv
module test_rxevt_handshake;

  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic       acc_en, acc_write, acc_first;
  logic [7:0] acc_wdata;
  logic [7:0] rd_data;
  logic       evt_begin, evt_end;
  logic [7:0] evt_chan, evt_btn;
  logic [2:0] mode_o;
  logic       req_drive_low;
  logic       req_line;

  assign req_line = ~req_drive_low;

  rxevt_handshake #(.DATA_W(8)) i_rxevt_handshake (
    .clk(clk), .rst_n(rst_n),
    .acc_en(acc_en), .acc_write(acc_write), .acc_first(acc_first),
    .acc_wdata(acc_wdata), .rd_data(rd_data),
    .evt_begin(evt_begin), .evt_end(evt_end),
    .evt_chan(evt_chan), .evt_btn(evt_btn),
    .mode_o(mode_o), .req_drive_low(req_drive_low), .req_line(req_line)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;

  // bench model
  logic [7:0] m_ptr;
  logic [2:0] m_mode;
  logic       m_chg, m_val, m_pv, m_pb;
  logic [7:0] m_chan, m_btn, m_pc, m_pt;

  task automatic check(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] m_read(logic [7:0] p);
    case (p)
      8'h00:   return {5'd0, m_mode};
      8'h01:   return {m_chg, m_val, 6'd0};
      8'h02:   return m_chan;
      8'h03:   return m_btn;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string rd_tag(logic [7:0] p);
    case (p)
      8'h00:   return "R2 mode read";
      8'h01:   return "R4 status read";
      8'h02:   return "R5 channel read";
      8'h03:   return "R10 button read";
      8'h06:   return "R7 ack read";
      default: return "R9 unmapped read";
    endcase
  endfunction

  function automatic logic m_req();
    return (m_mode == 3'd0) || (m_chg && (m_mode == 3'd2 || m_mode == 3'd4));
  endfunction

  function automatic logic m_listen();
    return (m_mode >= 3'd2) && (m_mode <= 3'd5);
  endfunction

  task automatic finish_cycle();
    @(posedge clk);
    @(negedge clk);
    acc_en = 1'b0; acc_write = 1'b0; acc_first = 1'b0;
    evt_begin = 1'b0; evt_end = 1'b0;
    check("R3 request line", req_drive_low, m_req());
    check("R2 mode output", mode_o, m_mode);
  endtask

  task automatic op_ptr(logic [7:0] a);
    acc_en = 1'b1; acc_write = 1'b1; acc_first = 1'b1; acc_wdata = a;
    m_ptr = a;
    finish_cycle();
  endtask

  task automatic op_wr(logic [7:0] d);
    acc_en = 1'b1; acc_write = 1'b1; acc_first = 1'b0; acc_wdata = d;
    if (m_ptr == 8'h00 && d <= 8'd6) m_mode = d[2:0];
    if (m_ptr == 8'h03) m_btn = d;
    m_ptr = m_ptr + 8'd1;
    finish_cycle();
  endtask

  task automatic op_rd();
    acc_en = 1'b1; acc_write = 1'b0; acc_first = 1'b0;
    check(rd_tag(m_ptr), rd_data, m_read(m_ptr));
    if (m_ptr == 8'h06) begin
      if (m_pv) begin
        m_chg = 1'b1; m_val = m_pb;
        if (m_pb) begin m_chan = m_pc; m_btn = m_pt; end
        m_pv = 1'b0;
      end else begin
        m_chg = 1'b0;
      end
    end
    m_ptr = m_ptr + 8'd1;
    finish_cycle();
  endtask

  task automatic op_evt(logic b, logic [7:0] ch, logic [7:0] bt);
    evt_begin = b; evt_end = !b; evt_chan = ch; evt_btn = bt;
    if (m_listen()) begin
      if (!m_chg) begin
        m_chg = 1'b1; m_val = b;
        if (b) begin m_chan = ch; m_btn = bt; end
      end else begin
        m_pv = 1'b1; m_pb = b;
        if (b) begin m_pc = ch; m_pt = bt; end
      end
    end
    finish_cycle();
  endtask

  task automatic rd_at(logic [7:0] a);
    op_ptr(a);
    op_rd();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    acc_en = 1'b0; acc_write = 1'b0; acc_first = 1'b0; acc_wdata = '0;
    evt_begin = 1'b0; evt_end = 1'b0; evt_chan = '0; evt_btn = '0;
    m_ptr = '0; m_mode = '0; m_chg = 0; m_val = 0; m_pv = 0; m_pb = 0;
    m_chan = '0; m_btn = '0; m_pc = '0; m_pt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 reset request low", req_drive_low, 1);
    check("R1 reset mode", mode_o, 0);
    check("R1 reset pointer reads mode", rd_data, 8'h00);
    op_rd();
    op_rd();                              // status at reset
    check("R1 reset status clear (req)", req_drive_low, 1);

    // events in mode 0 ignored
    op_evt(1'b1, 8'hAA, 8'hBB);
    rd_at(8'h01);

    // leave reset mode
    op_ptr(8'h00); op_wr(8'h01);
    check("R3 mode 1 releases request", req_drive_low, 0);

    // receive with request
    op_ptr(8'h00); op_wr(8'h02);
    op_evt(1'b1, 8'h5A, 8'h33);
    check("R5 begin drives request", req_drive_low, 1);
    op_ptr(8'h01); op_rd(); op_rd(); op_rd();   // status, channel, button
    op_evt(1'b1, 8'h11, 8'h22);                  // parked
    rd_at(8'h02);                                // R6 still 5A
    check("R6 frozen channel", m_chan, 8'h5A);
    rd_at(8'h06);                                // ack, parked reloaded
    check("R8 request held after ack with parked", req_drive_low, 1);
    op_ptr(8'h01); op_rd(); op_rd(); op_rd();
    op_evt(1'b0, 8'h00, 8'h00);                  // end parked
    rd_at(8'h06);
    rd_at(8'h01);                                // 0x80
    rd_at(8'h06);
    check("R7 request released after ack", req_drive_low, 0);
    rd_at(8'h01);

    // read-only / ignored writes
    op_ptr(8'h01); op_wr(8'hFF); rd_at(8'h01);
    op_ptr(8'h02); op_wr(8'h77); rd_at(8'h02);
    op_ptr(8'h06); op_wr(8'h55); rd_at(8'h01);
    op_ptr(8'h03); op_wr(8'h9C); rd_at(8'h03);
    check("R10 button write no request", req_drive_low, 0);
    op_ptr(8'h00); op_wr(8'h07); rd_at(8'h00);

    // polled receive
    op_ptr(8'h00); op_wr(8'h03);
    op_evt(1'b1, 8'h44, 8'h55);
    check("R3 polled mode no request", req_drive_low, 0);
    rd_at(8'h01);
    rd_at(8'h06);

    // pointer wrap
    op_ptr(8'hFF); op_rd(); op_rd();

    // seeded random mix
    for (int i = 0; i < 4000; i++) begin
      int sel;
      sel = $urandom_range(0, 6);
      case (sel)
        0: op_evt(1'b1, 8'($urandom), 8'($urandom));
        1: op_evt(1'b0, 8'($urandom), 8'($urandom));
        2: op_ptr(8'($urandom_range(0, 7)));
        3: op_wr(($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'($urandom_range(0, 7)));
        default: op_rd();
      endcase
    end

    summary();
    $finish;
  end

endmodule